// File: doc/BRIEF.md
# Control Pin Termination Request Detector

This block watches a single control pin, presented to it as the digital outputs of two level comparators, and turns a sustained level on that pin into a termination request. A high level asks for a normal end of charge. A low level asks for termination because of a fault. The two polarities are qualified on separate paths. Both paths first pass the pin through a synchronizer and a deglitch filter that counts millisecond ticks. The high path then samples on a short period. The low path samples on a long period and needs the same result on consecutive samples before it fires.

The high-path sample has lower priority than power packet communication. While the packet-busy flag is set, a sample that falls due is held back. It is taken on the first clock after the flag drops, so it is delayed but never lost. Each request is a one-clock pulse and fires once per qualified event. It can fire again only after the filtered pin has gone back to idle. The millisecond tick comes from elsewhere on the chip, so all timing parameters are given in ticks.

Top module: `ctlpin_term_det`

## Requirements
- R1: After reset both request outputs are low, and they stay low until a qualified event occurs.
- R2: The pin code uses bit 1 for "above upper threshold" and bit 0 for "below lower threshold". Code 2'b10 means high and 2'b01 means low. Codes 2'b00 and 2'b11 both mean idle and never produce a request.
- R3: A level reaches the samplers only after it has been stable for DG_MS consecutive ticks. Any change of the synchronized code restarts the count. A pulse of DG_MS-2 ms or shorter never produces a request.
- R4: With packet-busy low, a high level held for at least DG_MS+FAST_MS+2 ms produces exactly one end-of-charge pulse. The pulse appears no later than DG_MS+FAST_MS+1 ms after the level starts.
- R5: While packet-busy is high, no high-path sample is taken. A sample postponed this way is taken on the first clock after packet-busy falls. If the filtered level is high at that moment, the end-of-charge pulse appears on the next clock.
- R6: A high level held continuously always produces an end-of-charge pulse, including a 111 ms pulse that overlaps repeated packet-busy bursts.
- R7: A low level produces one fault pulse only after two consecutive slow samples (every SLOW_MS ticks) both see the filtered level low. Latency runs from SLOW_MS to 2*SLOW_MS+DG_MS+1 ms. A low shorter than SLOW_MS never faults.
- R8: Any slow sample that sees the filtered level not low clears the consecutive-hit count. Two low samples separated by an idle sample do not fault.
- R9: After a request fires, that request stays quiet until the filtered level has returned to idle. A later qualified event then fires it again.
- R10: Each request pulse lasts exactly one clock, and the two requests are never high in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_raw | input | 2 | Asynchronous comparator code for the control pin (bit 1 high, bit 0 low) |
| ms_tick | input | 1 | One-clock strobe once per millisecond |
| pkt_busy | input | 1 | High while a power packet is being sent; postpones high-path samples |
| eoc_req | output | 1 | One-clock end-of-charge request |
| fault_req | output | 1 | One-clock fault termination request |

## Verification
High pulses of random length are used to separate three cases: lengths short enough that the filter must swallow them, lengths long enough that one fast sample must catch them, and a band in between where either outcome is allowed. A high level held across a long busy period checks that the postponed sample fires on exactly the clock after busy falls. A 111 ms pulse cut into busy bursts checks that deferral never loses the request. Low levels are placed against the known slow-sample instants: one low covers two samples and must fault; one is shorter than a sample period and must not fault; and a low/idle/low pattern spans three samples and tells whether the hit count was cleared. The invalid code 11 and repeated high events check the idle decoding and the re-arm rule.

// File: rtl/ctlpin_pkg.sv
package ctlpin_pkg;

  typedef enum logic [1:0] {
    LVL_IDLE = 2'd0,
    LVL_HIGH = 2'd1,
    LVL_LOW  = 2'd2
  } lvl_e;

  // Comparator code to level: 10 high, 01 low, 00 and 11 idle.
  function automatic lvl_e decode_pin(input logic [1:0] code);
    case (code)
      2'b10:   return LVL_HIGH;
      2'b01:   return LVL_LOW;
      default: return LVL_IDLE;
    endcase
  endfunction

  // Consecutive-hit update for the slow path; saturates at the limit.
  function automatic int unsigned next_hits(input int unsigned hits,
                                            input logic         seen_low,
                                            input int unsigned  limit);
    if (!seen_low)     return 0;
    if (hits >= limit) return limit;
    return hits + 1;
  endfunction

endpackage

// File: rtl/ctlpin_sync.sv
module ctlpin_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else        stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else        stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/ctlpin_deglitch.sv
module ctlpin_deglitch
  import ctlpin_pkg::*;
#(
  parameter int DG_MS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  lvl_e lvl_in,
  output lvl_e lvl_out,
  output logic settle
);
  localparam int CW = $clog2(DG_MS + 1);

  lvl_e          cand;
  logic [CW-1:0] cnt;

  assign settle = tick && (lvl_in == cand) && (cnt == CW'(DG_MS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand    <= LVL_IDLE;
      cnt     <= '0;
      lvl_out <= LVL_IDLE;
    end else if (lvl_in != cand) begin
      cand <= lvl_in;
      cnt  <= '0;
    end else if (tick && cnt != CW'(DG_MS)) begin
      cnt <= cnt + 1'b1;
      if (settle) lvl_out <= cand;
    end
  end
endmodule

// File: rtl/ctlpin_period.sv
module ctlpin_period #(
  parameter int PERIOD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic due
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CW-1:0] cnt;

  assign due = tick && (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (due)  cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ctlpin_hi_path.sv
module ctlpin_hi_path
  import ctlpin_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic due,
  input  logic busy,
  input  lvl_e lvl,
  output logic take,
  output logic pending,
  output logic eoc
);
  logic armed;

  // A due sample waits out the packet; the first idle-bus clock takes it.
  assign take = !busy && (due || pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      armed   <= 1'b1;
      eoc     <= 1'b0;
    end else begin
      eoc <= 1'b0;
      if (due && busy) pending <= 1'b1;
      else if (take)   pending <= 1'b0;
      if (take && lvl == LVL_HIGH && armed) begin
        eoc   <= 1'b1;
        armed <= 1'b0;
      end else if (lvl == LVL_IDLE) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctlpin_lo_path.sv
module ctlpin_lo_path
  import ctlpin_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         due,
  input  lvl_e                         lvl,
  output logic [$clog2(CONFIRM+1)-1:0] hits,
  output logic                         fault
);
  localparam int HW = $clog2(CONFIRM + 1);

  logic          armed;
  logic [HW-1:0] hits_nx;

  assign hits_nx = HW'(next_hits(int'(hits), lvl == LVL_LOW, CONFIRM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hits  <= '0;
      armed <= 1'b1;
      fault <= 1'b0;
    end else begin
      fault <= 1'b0;
      if (due) hits <= hits_nx;
      if (due && armed && hits_nx == HW'(CONFIRM)) begin
        fault <= 1'b1;
        armed <= 1'b0;
      end else if (lvl == LVL_IDLE) begin
        armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ctlpin_term_det.sv
module ctlpin_term_det
  import ctlpin_pkg::*;
#(
  parameter int DG_MS   = 10,
  parameter int FAST_MS = 8,
  parameter int SLOW_MS = 250,
  parameter int CONFIRM = 2,
  parameter int SYNC_N  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pin_raw,
  input  logic       ms_tick,
  input  logic       pkt_busy,
  output logic       eoc_req,
  output logic       fault_req
);
  localparam int HW = $clog2(CONFIRM + 1);

  logic [1:0]    pin_sync;
  lvl_e          sync_lvl;
  lvl_e          dg_lvl;
  logic          dg_settle;
  logic          fast_due;
  logic          slow_due;
  logic          hi_take;
  logic          hi_pending;
  logic [HW-1:0] lo_hits;

  ctlpin_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_sync)
  );

  assign sync_lvl = decode_pin(pin_sync);

  ctlpin_deglitch #(.DG_MS(DG_MS)) u_dg (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick),
    .lvl_in(sync_lvl), .lvl_out(dg_lvl), .settle(dg_settle)
  );

  ctlpin_period #(.PERIOD(FAST_MS)) u_fast (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .due(fast_due)
  );

  ctlpin_period #(.PERIOD(SLOW_MS)) u_slow (
    .clk(clk), .rst_n(rst_n), .tick(ms_tick), .due(slow_due)
  );

  ctlpin_hi_path u_hi (
    .clk(clk), .rst_n(rst_n), .due(fast_due), .busy(pkt_busy),
    .lvl(dg_lvl), .take(hi_take), .pending(hi_pending), .eoc(eoc_req)
  );

  ctlpin_lo_path #(.CONFIRM(CONFIRM)) u_lo (
    .clk(clk), .rst_n(rst_n), .due(slow_due), .lvl(dg_lvl),
    .hits(lo_hits), .fault(fault_req)
  );
endmodule

// File: rtl/ctlpin_term_det_chk.sv
module ctlpin_term_det_chk
  import ctlpin_pkg::*;
#(
  parameter int CONFIRM = 2,
  parameter int HW      = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pkt_busy,
  input lvl_e          sync_lvl,
  input lvl_e          dg_lvl,
  input logic          hi_take,
  input logic          slow_due,
  input logic [HW-1:0] lo_hits,
  input logic          eoc_req,
  input logic          fault_req
);
  assert_filtered_from_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dg_lvl != $past(dg_lvl)) |-> (dg_lvl == $past(sync_lvl)));

  assert_eoc_needs_high_sample_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_req |-> ($past(hi_take) && $past(dg_lvl) == LVL_HIGH));

  assert_no_sample_when_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hi_take |-> !pkt_busy);

  assert_fault_needs_low_sample_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> ($past(slow_due) && $past(dg_lvl) == LVL_LOW));

  assert_hits_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_due && dg_lvl != LVL_LOW) |=> (lo_hits == '0));

  assert_hits_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lo_hits <= HW'(CONFIRM));

  assert_eoc_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_req |=> !eoc_req);

  assert_fault_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |=> !fault_req);

  assert_not_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(eoc_req && fault_req));
endmodule

bind ctlpin_term_det ctlpin_term_det_chk #(
  .CONFIRM(CONFIRM), .HW(HW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pkt_busy(pkt_busy), .sync_lvl(sync_lvl),
  .dg_lvl(dg_lvl), .hi_take(hi_take), .slow_due(slow_due),
  .lo_hits(lo_hits), .eoc_req(eoc_req), .fault_req(fault_req)
);

// File: tb/ctlpin_term_det_bench.sv
`timescale 1ns/1ps
module ctlpin_term_det_bench;
  localparam int DG   = 10;
  localparam int FAST = 8;
  localparam int SLOW = 250;
  localparam int TDIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] pin_raw = 2'b00;
  logic       ms_tick = 1'b0;
  logic       pkt_busy = 1'b0;
  logic       eoc_req, fault_req;

  int checks = 0, failures = 0;
  int eoc_cnt = 0, fault_cnt = 0;
  int tick_num = 0;
  int fault_tick = 0, eoc_cycle = 0, cyc = 0;
  logic ticking = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  ctlpin_term_det #(.DG_MS(DG), .FAST_MS(FAST), .SLOW_MS(SLOW), .CONFIRM(2)) u_ctlpin_term_det (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .ms_tick(ms_tick),
    .pkt_busy(pkt_busy), .eoc_req(eoc_req), .fault_req(fault_req)
  );

  // Observe away from the active edge.
  always @(negedge clk) begin
    cyc++;
    if (eoc_req)   begin eoc_cnt++; eoc_cycle = cyc; end
    if (fault_req) begin fault_cnt++; fault_tick = tick_num; end
  end

  initial begin
    wait (ticking);
    forever begin
      repeat (TDIV - 1) @(negedge clk);
      ms_tick = 1'b1;
      tick_num++;
      @(negedge clk);
      ms_tick = 1'b0;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ms(input int n);
    repeat (n * TDIV) @(negedge clk);
  endtask

  task automatic wait_tick(input int n);
    while (tick_num < n) @(negedge clk);
  endtask

  // Expected verdict for a high pulse of L ms with no busy: 0 none, 1 one, -1 either.
  function automatic int hi_expect(input int len_ms);
    if (len_ms <= DG - 2)        return 0;
    if (len_ms >= DG + FAST + 2) return 1;
    return -1;
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e0, f0, t0, c0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    check(eoc_req == 1'b0 && fault_req == 1'b0, "R1 reset", int'(eoc_req) + int'(fault_req), 0);
    rst_n = 1'b1;
    ticking = 1'b1;
    wait_ms(30);
    check(eoc_cnt == 0 && fault_cnt == 0, "R1 quiet", eoc_cnt + fault_cnt, 0);

    // R3: short pulses are swallowed.
    pin_raw = 2'b10; wait_ms(DG - 2); pin_raw = 2'b00; wait_ms(40);
    check(eoc_cnt == 0, "R3 short high", eoc_cnt, 0);
    pin_raw = 2'b01; wait_ms(DG - 3); pin_raw = 2'b00; wait_ms(40);
    check(fault_cnt == 0, "R3 short low", fault_cnt, 0);

    // R4: 20 ms high, latency bound.
    e0 = eoc_cnt; t0 = tick_num;
    pin_raw = 2'b10;
    while (eoc_cnt == e0 && tick_num - t0 < 20) @(negedge clk);
    check(eoc_cnt == e0 + 1, "R4 detect", eoc_cnt - e0, 1);
    check(tick_num - t0 <= DG + FAST + 1, "R4 latency", tick_num - t0, DG + FAST + 1);
    wait_ms(20 - (tick_num - t0)); pin_raw = 2'b00; wait_ms(40);
    check(eoc_cnt == e0 + 1, "R4 once", eoc_cnt - e0, 1);

    // R2: code 11 is idle.
    e0 = eoc_cnt; f0 = fault_cnt;
    pin_raw = 2'b11; wait_ms(2 * SLOW + 40); pin_raw = 2'b00; wait_ms(20);
    check(eoc_cnt == e0 && fault_cnt == f0, "R2 code11", (eoc_cnt - e0) + (fault_cnt - f0), 0);

    // R5: held high through busy; fires the clock after busy falls.
    e0 = eoc_cnt;
    pkt_busy = 1'b1; pin_raw = 2'b10; wait_ms(60);
    check(eoc_cnt == e0, "R5 held off", eoc_cnt - e0, 0);
    c0 = cyc; pkt_busy = 1'b0;
    repeat (4) @(negedge clk);
    check(eoc_cnt == e0 + 1, "R5 released", eoc_cnt - e0, 1);
    check(eoc_cycle - c0 == 2, "R5 timing", eoc_cycle - c0, 2);

    // R9: no repeat while still high; re-arm after idle.
    wait_ms(50);
    check(eoc_cnt == e0 + 1, "R9 no repeat", eoc_cnt - e0, 1);
    pin_raw = 2'b00; wait_ms(30);
    pin_raw = 2'b10; wait_ms(30); pin_raw = 2'b00; wait_ms(30);
    check(eoc_cnt == e0 + 2, "R9 rearm", eoc_cnt - e0, 2);

    // R6: 111 ms pulse cut into busy bursts.
    e0 = eoc_cnt;
    pin_raw = 2'b10;
    for (int k = 0; k < 7; k++) begin
      pkt_busy = 1'b1; wait_ms(15);
      pkt_busy = 1'b0; @(negedge clk);
    end
    wait_ms(6);
    pin_raw = 2'b00; wait_ms(30);
    check(eoc_cnt == e0 + 1, "R6 deferred pulse", eoc_cnt - e0, 1);

    // R7: low held; latency window.
    f0 = fault_cnt; t0 = tick_num;
    pin_raw = 2'b01;
    while (fault_cnt == f0 && tick_num - t0 < 2 * SLOW + DG + 5) @(negedge clk);
    check(fault_cnt == f0 + 1, "R7 fault", fault_cnt - f0, 1);
    check(fault_tick - t0 >= SLOW && fault_tick - t0 <= 2 * SLOW + DG + 1,
          "R7 latency", fault_tick - t0, 2 * SLOW);
    pin_raw = 2'b00; wait_ms(30);
    // R7: low shorter than one slow period.
    f0 = fault_cnt;
    pin_raw = 2'b01; wait_ms(SLOW - 50); pin_raw = 2'b00; wait_ms(SLOW + 30);
    check(fault_cnt == f0, "R7 short low", fault_cnt - f0, 0);

    // R8: low / idle / low over three aligned slow samples.
    begin
      int s1;
      s1 = (tick_num / SLOW + 2) * SLOW;
      f0 = fault_cnt;
      wait_tick(s1 - 100); pin_raw = 2'b01;
      wait_tick(s1 + 100); pin_raw = 2'b00;
      wait_tick(s1 + SLOW + 100); pin_raw = 2'b01;
      wait_tick(s1 + 2 * SLOW + 100); pin_raw = 2'b00;
      wait_ms(30);
      check(fault_cnt == f0, "R8 hit clear", fault_cnt - f0, 0);
    end

    // Random high and short low pulses, no busy.
    for (int n = 0; n < 30; n++) begin
      int len, kind, exp;
      len  = int'($urandom_range(1, 40));
      kind = int'($urandom_range(0, 2));
      e0 = eoc_cnt; f0 = fault_cnt;
      if (kind == 1) begin
        pin_raw = 2'b01; wait_ms((len % (DG - 2)) + 1);
      end else begin
        pin_raw = 2'b10; wait_ms(len);
      end
      pin_raw = 2'b00; wait_ms(DG + FAST + 6);
      if (kind == 1) begin
        check(fault_cnt == f0 && eoc_cnt == e0, "R3 random low", fault_cnt - f0, 0);
      end else begin
        exp = hi_expect(len);
        if (exp >= 0) check(eoc_cnt - e0 == exp, "R4 random high", eoc_cnt - e0, exp);
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule